// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Unit

This unit translates a logical address into a physical address through a small fully associative cache of page translations. The upper bits of the logical address form the page number and the lower bits the page offset. Every cache slot is compared at once against the page number and the identifier of the running address space. On a match, the cached frame number is joined to the unchanged offset and reported in the same cycle, with no memory traffic.

On a miss, the page number is first checked against a table-length input; a number at or beyond the length ends the request with a length fault. Otherwise one page-table entry is read from memory at the table base plus the page number, over a request/valid handshake. An entry whose valid bit is set completes the translation and is written into the cache at a round-robin slot. An entry whose valid bit is clear ends the request with an invalid-page fault. A flush input empties the cache.

Top module: `tlb_xlate_unit`

## Requirements
- R1: After reset, done_o and mem_req_o are low, req_ready_o is high and the cache is empty, so the first request of any page goes to memory.
- R2: The page number is vaddr_i[VA_W-1:OFF_W] and the offset is vaddr_i[OFF_W-1:0]; a successful translation returns paddr_o = {frame, offset}.
- R3: A request whose page number and asid_i match a cached slot raises done_o combinationally in the cycle it is presented, with fault_o = 0, and issues no memory request.
- R4: A cached slot matches only when its stored identifier equals asid_i; the same page under another identifier misses and is walked.
- R5: On a miss with page number >= ptlr_i, done_o rises one cycle after acceptance with fault_o = 1 and no memory request is issued.
- R6: On a legal miss, mem_req_o is raised with mem_addr_o = ptbr_i + page number and both are held until the cycle mem_rvalid_i is high.
- R7: A table entry holds the valid bit at mem_rdata_i[PFN_W] and the frame at mem_rdata_i[PFN_W-1:0]; with the valid bit clear, done_o is raised with fault_o = 2 and nothing is cached, so a repeat request walks again.
- R8: With the valid bit set, done_o rises one cycle after mem_rvalid_i with fault_o = 0 and the translated address, and the page is cached so a repeat request hits.
- R9: Fills go to slots in round-robin order starting at slot 0 and wrapping after ENTRIES fills; with ENTRIES = 8, the ninth distinct fill after a flush evicts the first page filled and leaves the second resident.
- R10: A cycle with flush_i high invalidates every slot; a later request to a previously cached page misses.
- R11: req_ready_o is low from acceptance of a miss until its done cycle, and requests presented meanwhile are ignored (no extra memory request, no extra done).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all cached translations |
| asid_i | input | ASID_W | Identifier of the running address space |
| ptbr_i | input | MEM_AW | Page-table base address |
| ptlr_i | input | VPN_W+1 | Page-table length in entries |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Unit can accept a request |
| vaddr_i | input | VA_W | Logical address |
| done_o | output | 1 | Translation or fault complete |
| paddr_o | output | PA_W | Physical address, valid with done_o and fault_o = 0 |
| fault_o | output | 2 | 0 none, 1 length violation, 2 invalid page |
| mem_req_o | output | 1 | Page-table read request |
| mem_addr_o | output | MEM_AW | Page-table entry address |
| mem_rvalid_i | input | 1 | Page-table read data valid |
| mem_rdata_i | input | PFN_W+1 | Valid bit and frame number |

## Verification
The hardest state to reach is a full cache whose round-robin pointer has wrapped, because only distinct legal misses advance it and a hit never does. The bench flushes, then walks nine consecutive pages, and probes the second page before the first so the probe of the evicted page does not itself disturb the surviving slot. A request held high through a walk checks that nothing is accepted while busy.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_LEN  = 2'd1,
    FLT_INV  = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_MEM  = 2'd1,
    WK_RESP = 2'd2
  } walk_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 8,
  parameter int PFN_W   = 8,
  parameter int ASID_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [VPN_W-1:0]  look_vpn_i,
  input  logic [ASID_W-1:0] look_asid_i,
  output logic              hit_o,
  output logic [PFN_W-1:0]  hit_pfn_o,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] match;
  logic [PFN_W-1:0]   pfn_mask [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign match[g]    = valid_q[g] && (vpn_q[g] == look_vpn_i) && (asid_q[g] == look_asid_i);
    assign pfn_mask[g] = match[g] ? pfn_q[g] : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        vpn_q[g]   <= '0;
        asid_q[g]  <= '0;
        pfn_q[g]   <= '0;
      end else if (flush_i) begin
        valid_q[g] <= 1'b0;
      end else if (fill_i && (ptr_q == PTR_W'(g))) begin
        valid_q[g] <= 1'b1;
        vpn_q[g]   <= fill_vpn_i;
        asid_q[g]  <= fill_asid_i;
        pfn_q[g]   <= fill_pfn_i;
      end
    end
  end

  always_comb begin
    hit_pfn_o = '0;
    for (int i = 0; i < ENTRIES; i++) hit_pfn_o |= pfn_mask[i];
  end
  assign hit_o = |match;

  // round-robin victim pointer, advances only on a fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (flush_i) ptr_q <= '0;
    else if (fill_i) ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R3
  hit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(match));
  // R10
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) flush_i |=> !hit_o);
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 8,
  parameter int OFF_W  = 8,
  parameter int PFN_W  = 8,
  parameter int ASID_W = 4,
  parameter int MEM_AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [MEM_AW-1:0] ptbr_i,
  input  logic [VPN_W:0]    ptlr_i,
  output logic              idle_o,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PFN_W:0]    mem_rdata_i,
  output logic              fill_o,
  output logic [VPN_W-1:0]  fill_vpn_o,
  output logic [ASID_W-1:0] fill_asid_o,
  output logic [PFN_W-1:0]  fill_pfn_o,
  output logic              resp_o,
  output logic [PFN_W+OFF_W-1:0] resp_paddr_o,
  output logic [1:0]        resp_fault_o
);
  walk_state_e state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  logic [ASID_W-1:0] asid_q;
  logic [MEM_AW-1:0] addr_q;
  logic [PFN_W-1:0]  pfn_q;
  fault_e            fault_q;
  logic              too_long;
  logic              pte_ok;

  assign too_long = {1'b0, vpn_i} >= ptlr_i;
  assign pte_ok   = mem_rdata_i[PFN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WK_IDLE;
      vpn_q   <= '0;
      off_q   <= '0;
      asid_q  <= '0;
      addr_q  <= '0;
      pfn_q   <= '0;
      fault_q <= FLT_NONE;
    end else begin
      case (state_q)
        WK_IDLE: if (start_i) begin
          vpn_q  <= vpn_i;
          off_q  <= off_i;
          asid_q <= asid_i;
          addr_q <= ptbr_i + MEM_AW'(vpn_i);
          if (too_long) begin
            fault_q <= FLT_LEN;
            state_q <= WK_RESP;
          end else begin
            state_q <= WK_MEM;
          end
        end
        WK_MEM: if (mem_rvalid_i) begin
          pfn_q   <= mem_rdata_i[PFN_W-1:0];
          fault_q <= pte_ok ? FLT_NONE : FLT_INV;
          state_q <= WK_RESP;
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign idle_o       = (state_q == WK_IDLE);
  assign mem_req_o    = (state_q == WK_MEM);
  assign mem_addr_o   = addr_q;
  assign fill_o       = mem_req_o && mem_rvalid_i && pte_ok;
  assign fill_vpn_o   = vpn_q;
  assign fill_asid_o  = asid_q;
  assign fill_pfn_o   = mem_rdata_i[PFN_W-1:0];
  assign resp_o       = (state_q == WK_RESP);
  assign resp_paddr_o = {pfn_q, off_q};
  assign resp_fault_o = resp_o ? fault_q : FLT_NONE;

  // R6
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R5
  len_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && start_i && too_long) |=> (resp_o && resp_fault_o == FLT_LEN));
  // R8
  resp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o |=> idle_o);
endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit
  import tlb_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 8,
  parameter int PFN_W   = 8,
  parameter int ASID_W  = 4,
  parameter int ENTRIES = 8,
  parameter int MEM_AW  = 16,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [MEM_AW-1:0] ptbr_i,
  input  logic [VPN_W:0]    ptlr_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   vaddr_i,
  output logic              done_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic [1:0]        fault_o,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PFN_W:0]    mem_rdata_i
);
  logic [VPN_W-1:0]  vpn;
  logic [OFF_W-1:0]  off;
  logic              hit, hit_done, miss_start;
  logic [PFN_W-1:0]  hit_pfn;
  logic              fill;
  logic [VPN_W-1:0]  fill_vpn;
  logic [ASID_W-1:0] fill_asid;
  logic [PFN_W-1:0]  fill_pfn;
  logic              idle, resp;
  logic [PA_W-1:0]   resp_paddr;
  logic [1:0]        resp_fault;

  assign vpn = vaddr_i[VA_W-1:OFF_W];
  assign off = vaddr_i[OFF_W-1:0];

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_cam (
    .clk_i, .rst_ni, .flush_i,
    .look_vpn_i(vpn), .look_asid_i(asid_i),
    .hit_o(hit), .hit_pfn_o(hit_pfn),
    .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid), .fill_pfn_i(fill_pfn)
  );

  assign req_ready_o = idle;
  assign hit_done    = idle && req_valid_i && hit;
  assign miss_start  = idle && req_valid_i && !hit;

  tlb_walker #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .MEM_AW(MEM_AW)) u_walk (
    .clk_i, .rst_ni,
    .start_i(miss_start), .vpn_i(vpn), .off_i(off), .asid_i(asid_i),
    .ptbr_i, .ptlr_i,
    .idle_o(idle),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .fill_o(fill), .fill_vpn_o(fill_vpn), .fill_asid_o(fill_asid), .fill_pfn_o(fill_pfn),
    .resp_o(resp), .resp_paddr_o(resp_paddr), .resp_fault_o(resp_fault)
  );

  assign done_o  = hit_done || resp;
  assign paddr_o = hit_done ? {hit_pfn, off} : resp_paddr;
  assign fault_o = hit_done ? FLT_NONE : resp_fault;

  // R3
  no_mem_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) hit_done |-> !mem_req_o);
  // R7
  fault_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (fault_o != 2'd0) |-> done_o);
  // R11
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_req_o |-> !req_ready_o);
endmodule

// File: tb/tlb_xlate_unit_bench.sv
module tlb_xlate_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [3:0]  asid = 4'h1;
  logic [15:0] ptbr = 16'h0100;
  logic [8:0]  ptlr = 9'd64;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] vaddr = '0;
  logic        done;
  logic [15:0] paddr;
  logic [1:0]  fault;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [8:0]  mem_rdata = '0;

  int n_chk = 0, n_fail = 0, mem_cnt = 0, lat = 0;
  logic [15:0] last_maddr = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  tlb_xlate_unit u_tlb_xlate_unit (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .asid_i(asid),
    .ptbr_i(ptbr), .ptlr_i(ptlr),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .vaddr_i(vaddr),
    .done_o(done), .paddr_o(paddr), .fault_o(fault),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  // table entry model: frame = addr low byte ^ 5A, invalid when low nibble is F
  function automatic logic [8:0] pte(input logic [15:0] a);
    return {(a[3:0] != 4'hF), a[7:0] ^ 8'h5A};
  endfunction

  // memory model, two cycles of latency
  always @(negedge clk) begin
    if (mem_req && !mem_rvalid) begin
      lat++;
      if (lat == 2) begin
        mem_rvalid = 1'b1;
        mem_rdata  = pte(mem_addr);
        last_maddr = mem_addr;
        mem_cnt++;
        lat = 0;
      end
    end else begin
      mem_rvalid = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xlate(input logic [15:0] va, input logic [3:0] as,
                       output logic [15:0] pa, output logic [1:0] flt,
                       output int cyc, output int md);
    int m0;
    m0 = mem_cnt;
    @(negedge clk);
    req_valid = 1'b1; vaddr = va; asid = as;
    #1;
    cyc = 0;
    if (done) begin
      pa = paddr; flt = fault;
      @(posedge clk); #1 req_valid = 1'b0;
    end else begin
      @(posedge clk); #1 req_valid = 1'b0;
      for (cyc = 1; cyc < 30; cyc++) begin
        @(negedge clk);
        if (done) break;
      end
      pa = paddr; flt = fault;
    end
    md = mem_cnt - m0;
  endtask

  // vaddr, asid, expected paddr, expected fault, expected hit
  localparam logic [38:0] VECS [8] = '{
    {16'h0312, 4'h1, 16'h5912, 2'd0, 1'b0},
    {16'h03AB, 4'h1, 16'h59AB, 2'd0, 1'b1},
    {16'h0744, 4'h1, 16'h5D44, 2'd0, 1'b0},
    {16'h0F00, 4'h1, 16'h0000, 2'd2, 1'b0},
    {16'h0F01, 4'h1, 16'h0000, 2'd2, 1'b0},
    {16'h4000, 4'h1, 16'h0000, 2'd1, 1'b0},
    {16'h3E10, 4'h1, 16'h6410, 2'd0, 1'b0},
    {16'h0777, 4'h1, 16'h5D77, 2'd0, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] pa;
    logic [1:0]  flt;
    int cyc, md, m0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!done && !mem_req && req_ready, "R1 reset outputs", {done, mem_req, req_ready}, 3'b001);

    for (int i = 0; i < 8; i++) begin
      xlate(VECS[i][38:23], VECS[i][22:19], pa, flt, cyc, md);
      chk(flt == VECS[i][2:1], $sformatf("R5/R7 vec%0d fault", i), flt, VECS[i][2:1]);
      if (VECS[i][2:1] == 2'd0)
        chk(pa == VECS[i][18:3], $sformatf("R2/R8 vec%0d paddr", i), pa, VECS[i][18:3]);
      if (VECS[i][0]) begin
        // R3 hit: same cycle, no memory
        chk(cyc == 0 && md == 0, $sformatf("R3 vec%0d hit", i), {cyc[15:0], md[15:0]}, 0);
      end else if (VECS[i][2:1] == 2'd1) begin
        // R5 length fault one cycle later, no memory
        chk(cyc == 1 && md == 0, $sformatf("R5 vec%0d timing", i), {cyc[15:0], md[15:0]}, 32'h0001_0000);
      end else begin
        // R6 / R8 walk: one memory read at base + page
        chk(md == 1 && last_maddr == 16'h0100 + {8'h00, VECS[i][38:31]},
            $sformatf("R6 vec%0d walk", i), last_maddr, 16'h0100 + {8'h00, VECS[i][38:31]});
        chk(cyc >= 2, $sformatf("R1/R8 vec%0d miss", i), cyc, 2);
      end
    end

    // R4: other identifier misses, original still hits
    xlate(16'h0312, 4'h2, pa, flt, cyc, md);
    chk(md == 1 && pa == 16'h5912, "R4 other asid walks", {md[7:0], pa}, {8'd1, 16'h5912});
    xlate(16'h0355, 4'h1, pa, flt, cyc, md);
    chk(cyc == 0 && pa == 16'h5955, "R4 own asid hits", pa, 16'h5955);

    // R10: flush then cached page misses
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    xlate(16'h0700, 4'h1, pa, flt, cyc, md);
    chk(md == 1 && pa == 16'h5D00, "R10 miss after flush", md, 1);

    // R9: round robin replacement
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int v = 16; v < 24; v++) xlate({v[7:0], 8'h00}, 4'h1, pa, flt, cyc, md);
    m0 = 0;
    for (int v = 16; v < 24; v++) begin
      xlate({v[7:0], 8'h01}, 4'h1, pa, flt, cyc, md);
      if (md != 0) m0++;
    end
    chk(m0 == 0, "R9 all eight resident", m0, 0);
    xlate(16'h1800, 4'h1, pa, flt, cyc, md);
    xlate(16'h1102, 4'h1, pa, flt, cyc, md);
    chk(md == 0 && pa == 16'h4B02, "R9 second fill survives", {md[7:0], pa}, 16'h4B02);
    xlate(16'h1003, 4'h1, pa, flt, cyc, md);
    chk(md == 1 && pa == 16'h4A03, "R9 first fill evicted", {md[7:0], pa}, {8'd1, 16'h4A03});

    // R11: requests during a walk are ignored
    m0 = mem_cnt;
    @(negedge clk);
    req_valid = 1'b1; vaddr = 16'h2001; asid = 4'h1;
    @(negedge clk);
    vaddr = 16'h2102;
    chk(!req_ready && mem_req && mem_addr == 16'h0120, "R11/R6 busy walk", {req_ready, mem_req, mem_addr}, {2'b01, 16'h0120});
    for (int k = 0; k < 30; k++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done && paddr == 16'h7A01 && fault == 2'd0, "R11 first request result", paddr, 16'h7A01);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!mem_req && !done && (mem_cnt - m0) == 1, "R11 no extra walk", {mem_req, done}, 0);

    // R7: invalid entry not cached
    xlate(16'h2F00, 4'h1, pa, flt, cyc, md);
    chk(flt == 2'd2 && md == 1, "R7 invalid fault", flt, 2);
    xlate(16'h2F00, 4'h1, pa, flt, cyc, md);
    chk(flt == 2'd2 && md == 1, "R7 invalid walked again", md, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule